// File: doc/BRIEF.md
# Instruction trace enable filter

This block decides, for every retired instruction or exception that the processor reports, whether that event enters the instruction trace. Each event arrives with its security state, its exception level and a two-bit kind tag. The block combines these with a configuration word and a live started/stopped status from outside start/stop logic. It returns a trace-enable flag in the same cycle as the event.

The configuration word is 32 bits wide and is reached through a simple register port with separate write and read strobes. It holds one suppress bit for each exception level in each security state. Suppress bits for levels that cannot be traced are tied to zero. Two force bits make reset and system-error exceptions always traced. Without its force bit, such an exception copies the decision made for the event just before it, and the block keeps that decision in a one-bit history flop. The started/stopped status can be read back through the same port.

Top module: `trace_view_filter`

## Requirements
- R1: After reset the register reads all zeros except bit 9, and the first event after reset counts as having an untraced predecessor.
- R2: A write stores bits 22:20 (Non-secure suppress, EL0 at bit 20, EL1 at 21, EL2 at 22), bits 19, 17 and 16 (Secure suppress for EL3, EL1 and EL0), bit 11 (force system error) and bit 10 (force reset), and a later read returns them.
- R3: Bits 31:24, 23, 18, 15:12, 9 and 8 are not changed by writes. All of them except bit 9 always read as zero.
- R4: Read bit 9 equals the ss_started input (1 = started) in the cycle of the read strobe.
- R5: reg_rdata carries the read value in the cycle after reg_rd_en and is zero in a cycle that does not follow a read strobe. A read and a write in the same cycle return the value from before the write.
- R6: For kind 0 (instruction) or kind 1 (other exception), trace_en is 1 exactly when ss_started is 1 and the suppress bit for the event's security state (evt_secure = 1 is Secure) and level is 0.
- R7: Non-secure EL3 and Secure EL2 events are never suppressed by level bits; only ss_started gates them.
- R8: A kind 2 (reset exception) event is traced whenever bit 10 is 1, and otherwise only when the previous valid event was traced.
- R9: A kind 3 (system error) event is traced whenever bit 11 is 1, and otherwise only when the previous valid event was traced.
- R10: trace_en is 0 when evt_valid is 0, and cycles without a valid event leave the recorded history unchanged.
- R11: A write affects events from the next cycle on. An event in the same cycle as the write uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| ss_started | input | 1 | Start/stop status, 1 = started |
| evt_valid | input | 1 | An event is presented this cycle |
| evt_secure | input | 1 | Event security state, 1 = Secure |
| evt_level | input | 2 | Event exception level 0..3 |
| evt_kind | input | 2 | 0 instruction, 1 exception, 2 reset, 3 system error |
| trace_en | output | 1 | Trace decision for this event |

## Verification
trace_en is combinational on the event inputs and depends on the register and history state as they stood after the previous clock edge. The bench therefore drives each event just after a falling edge and compares trace_en a nanosecond later. Only after that comparison does it apply the cycle's write and history update to its model. reg_rdata is due one edge after the strobe: the bench predicts it from the register value before that cycle's write and from the status at the strobe, then compares it at the next falling edge. In cycles without a read it expects zero.

// File: rtl/tvf_pkg.sv
package tvf_pkg;
  localparam int REG_W       = 32;
  localparam int LVL_W       = 2;
  localparam int NUM_LVL     = 1 << LVL_W;
  localparam int NS_DIS_LSB  = 20;
  localparam int S_DIS_LSB   = 16;
  localparam int FRC_SERR_B  = 11;
  localparam int FRC_RST_B   = 10;
  localparam int SS_STAT_B   = 9;
  // levels that exist in each security state; others are read-as-zero
  localparam logic [NUM_LVL-1:0] NS_IMPL = 4'b0111;
  localparam logic [NUM_LVL-1:0] S_IMPL  = 4'b1011;

  typedef enum logic [1:0] {
    EVT_INSTR  = 2'd0,
    EVT_EXC    = 2'd1,
    EVT_RESET  = 2'd2,
    EVT_SERROR = 2'd3
  } evt_kind_e;

  typedef struct packed {
    logic [NUM_LVL-1:0] ns_dis;
    logic [NUM_LVL-1:0] s_dis;
    logic               frc_serr;
    logic               frc_rst;
  } cfg_t;

  function automatic logic [REG_W-1:0] cfg_to_word(cfg_t c, logic started);
    logic [REG_W-1:0] w;
    w = '0;
    w[NS_DIS_LSB +: NUM_LVL] = c.ns_dis & NS_IMPL;
    w[S_DIS_LSB  +: NUM_LVL] = c.s_dis & S_IMPL;
    w[FRC_SERR_B] = c.frc_serr;
    w[FRC_RST_B]  = c.frc_rst;
    w[SS_STAT_B]  = started;
    return w;
  endfunction

  function automatic logic level_suppressed(cfg_t c, logic secure, logic [LVL_W-1:0] lvl);
    return secure ? c.s_dis[lvl] : c.ns_dis[lvl];
  endfunction
endpackage

// File: rtl/tvf_cfg_regs.sv
module tvf_cfg_regs
  import tvf_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] wdata,
  input  logic         ss_started,
  output logic [W-1:0] rdata,
  output cfg_t         cfg
);
  logic [NUM_LVL-1:0] ns_q, s_q;
  logic               frc_serr_q, frc_rst_q;

  // one flop per implemented level bit, constant zero elsewhere
  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    if (NS_IMPL[i]) begin : g_ns
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)     ns_q[i] <= 1'b0;
        else if (wr_en) ns_q[i] <= wdata[NS_DIS_LSB + i];
    end else begin : g_ns_raz
      assign ns_q[i] = 1'b0;
    end
    if (S_IMPL[i]) begin : g_s
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)     s_q[i] <= 1'b0;
        else if (wr_en) s_q[i] <= wdata[S_DIS_LSB + i];
    end else begin : g_s_raz
      assign s_q[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frc_serr_q <= 1'b0;
      frc_rst_q  <= 1'b0;
    end else if (wr_en) begin
      frc_serr_q <= wdata[FRC_SERR_B];
      frc_rst_q  <= wdata[FRC_RST_B];
    end
  end

  assign cfg = '{ns_dis: ns_q, s_dis: s_q, frc_serr: frc_serr_q, frc_rst: frc_rst_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= cfg_to_word(cfg, ss_started);
    else            rdata <= '0;
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata;
endmodule

// File: rtl/tvf_level_gate.sv
module tvf_level_gate
  import tvf_pkg::*;
(
  input  cfg_t             cfg,
  input  logic             ss_started,
  input  logic             secure,
  input  logic [LVL_W-1:0] level,
  output logic             view_ok
);
  logic suppressed;
  assign suppressed = level_suppressed(cfg, secure, level);
  assign view_ok    = ss_started & ~suppressed;
endmodule

// File: rtl/tvf_event_judge.sv
module tvf_event_judge
  import tvf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      evt_valid,
  input  evt_kind_e kind,
  input  logic      view_ok,
  input  logic      frc_rst,
  input  logic      frc_serr,
  output logic      trace_en,
  output logic      prev_traced
);
  logic decide;

  always_comb begin
    unique case (kind)
      EVT_RESET:  decide = frc_rst  | prev_traced;
      EVT_SERROR: decide = frc_serr | prev_traced;
      default:    decide = view_ok;
    endcase
  end

  assign trace_en = evt_valid & decide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         prev_traced <= 1'b0;
    else if (evt_valid) prev_traced <= decide;
  end
endmodule

// File: rtl/trace_view_filter.sv
module trace_view_filter
  import tvf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_rd_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ss_started,
  input  logic             evt_valid,
  input  logic             evt_secure,
  input  logic [LVL_W-1:0] evt_level,
  input  logic [1:0]       evt_kind,
  output logic             trace_en
);
  cfg_t      cfg;
  logic      view_ok;
  logic      prev_traced;
  evt_kind_e kind;

  assign kind = evt_kind_e'(evt_kind);

  tvf_cfg_regs #(.W(REG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .rd_en      (reg_rd_en),
    .wdata      (reg_wdata),
    .ss_started (ss_started),
    .rdata      (reg_rdata),
    .cfg        (cfg)
  );

  tvf_level_gate u_gate (
    .cfg        (cfg),
    .ss_started (ss_started),
    .secure     (evt_secure),
    .level      (evt_level),
    .view_ok    (view_ok)
  );

  tvf_event_judge u_judge (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_valid   (evt_valid),
    .kind        (kind),
    .view_ok     (view_ok),
    .frc_rst     (cfg.frc_rst),
    .frc_serr    (cfg.frc_serr),
    .trace_en    (trace_en),
    .prev_traced (prev_traced)
  );
endmodule

// File: rtl/tvf_checker.sv
module tvf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_rd_en,
  input logic [31:0] reg_rdata,
  input logic        ss_started,
  input logic        evt_valid,
  input logic [1:0]  evt_kind,
  input logic        trace_en,
  input logic        frc_rst,
  input logic        frc_serr,
  input logic        prev_traced
);
  // R10
  idle_no_trace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |-> !trace_en);
  // R10
  history_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> $stable(prev_traced));
  // R10
  history_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> prev_traced == $past(trace_en));
  // R5
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> reg_rdata == 32'h0);
  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> (reg_rdata & ~32'h007B_0E00) == 32'h0);
  // R4
  status_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> reg_rdata[9] == $past(ss_started));
  // R8
  force_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 2'd2) |-> trace_en == (frc_rst | prev_traced));
  // R9
  force_serr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 2'd3) |-> trace_en == (frc_serr | prev_traced));
  // R6
  stopped_no_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_kind[1] && !ss_started) |-> !trace_en);
endmodule

bind trace_view_filter tvf_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_rd_en   (reg_rd_en),
  .reg_rdata   (reg_rdata),
  .ss_started  (ss_started),
  .evt_valid   (evt_valid),
  .evt_kind    (evt_kind),
  .trace_en    (trace_en),
  .frc_rst     (cfg.frc_rst),
  .frc_serr    (cfg.frc_serr),
  .prev_traced (prev_traced)
);

// File: tb/tb_trace_view_filter.sv
`timescale 1ns/1ps
module tb_trace_view_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ss_started = 1'b0;
  logic        evt_valid = 1'b0, evt_secure = 1'b0;
  logic [1:0]  evt_level = '0, evt_kind = '0;
  logic        trace_en;

  int compared = 0, mismatched = 0;
  logic [31:0] m_reg;       // writable bits only
  logic        m_prev;
  logic [31:0] m_rd_next;
  bit          done = 0;

  always #2.5 clk = ~clk;

  trace_view_filter dut (.*);

  localparam logic [31:0] WMASK = 32'h007B_0C00;

  function automatic logic view_of(logic [31:0] r, logic st, logic sec, logic [1:0] lvl);
    logic [3:0] dis;
    dis = sec ? r[19:16] : r[23:20];
    return st && !dis[lvl];
  endfunction

  function automatic logic judge(logic [31:0] r, logic prev, logic st, logic sec,
                                 logic [1:0] lvl, logic [1:0] kind, logic v);
    logic d;
    if (kind == 2'd2)      d = r[10] || prev;
    else if (kind == 2'd3) d = r[11] || prev;
    else                   d = view_of(r, st, sec, lvl);
    return v && d;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of(logic [1:0] kind, logic v, logic sec, logic [1:0] lvl);
    if (!v) return "R10";
    if (kind == 2'd2) return "R8";
    if (kind == 2'd3) return "R9";
    if ((sec && lvl == 2'd2) || (!sec && lvl == 2'd3)) return "R7";
    return "R6";
  endfunction

  // one clock: drive, check trace_en, advance model
  task automatic step(logic we, logic [31:0] wd, logic re, logic st,
                      logic v, logic sec, logic [1:0] lvl, logic [1:0] kind, string rtag);
    @(negedge clk);
    chk(rtag, reg_rdata, m_rd_next);
    reg_wr_en = we; reg_wdata = wd; reg_rd_en = re; ss_started = st;
    evt_valid = v; evt_secure = sec; evt_level = lvl; evt_kind = kind;
    #1;
    chk(we ? "R11" : tag_of(kind, v, sec, lvl), {31'h0, trace_en},
        {31'h0, judge(m_reg, m_prev, st, sec, lvl, kind, v)});
    m_rd_next = re ? (m_reg | (32'(st) << 9)) : 32'h0;
    if (v) m_prev = judge(m_reg, m_prev, st, sec, lvl, kind, v);
    if (we) m_reg = wd & WMASK;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_reg = '0; m_prev = 1'b0; m_rd_next = '0;
    ss_started = 1'b1;
    #12 rst_n = 1'b1;
    // R1: reset read and untraced predecessor for a reset exception
    step(0, 0, 1, 1, 1, 0, 2'd0, 2'd2, "R1");
    step(0, 0, 0, 1, 0, 0, 2'd0, 2'd0, "R1");
    // R2 / R3: write all ones, read back
    step(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 2'd0, 2'd0, "R5");
    step(0, 0, 1, 0, 0, 0, 2'd0, 2'd0, "R2");
    step(0, 0, 0, 1, 0, 0, 2'd0, 2'd0, "R3");
    // R7: suppress everything, NS EL3 and S EL2 still traced when started
    step(0, 0, 0, 1, 1, 0, 2'd3, 2'd0, "R7");
    step(0, 0, 0, 1, 1, 1, 2'd2, 2'd1, "R7");
    step(0, 0, 0, 1, 1, 1, 2'd1, 2'd0, "R6");
    // R11: write in same cycle as an event uses old settings
    step(1, 32'h0, 0, 1, 1, 1, 2'd1, 2'd0, "R5");
    step(0, 0, 0, 1, 1, 1, 2'd1, 2'd0, "R5");
    // R5: read and write in same cycle return old value
    step(1, 32'h0000_0C00, 1, 1, 0, 0, 2'd0, 2'd0, "R5");
    step(0, 0, 1, 0, 0, 0, 2'd0, 2'd0, "R5");
    // R8/R9: forced after an untraced event
    step(0, 0, 0, 0, 1, 0, 2'd0, 2'd0, "R4");
    step(0, 0, 0, 0, 1, 0, 2'd0, 2'd2, "R4");
    step(0, 0, 0, 0, 1, 0, 2'd0, 2'd3, "R4");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic we, re;
      we = ($urandom % 8) == 0;
      re = ($urandom % 4) == 0;
      step(we, $urandom, re, ($urandom % 4) != 0, ($urandom % 4) != 0,
           1'($urandom), 2'($urandom), 2'($urandom), re ? "R4" : "R5");
    end
    step(0, 0, 0, 1, 0, 0, 2'd0, 2'd0, "R5");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule